// File: doc/BRIEF.md
# Posted Store Write Buffer

This block decouples a processor's store path from a shared, arbitrated memory write port. Every store hands the buffer one address and data pair and retires at once. The buffer keeps these pairs in arrival order in a small distributed-RAM queue. It offers the oldest pair to memory whenever it holds at least one, and keeps offering it until memory grants the write.

The core stalls a store only while the queue holds all of its entries. A push that arrives in the same cycle as a grant is still taken, even when the queue is full, because the granted entry frees its slot at the same clock edge. An empty flag tells a fence or software when every posted store has reached memory.

Internally, a separate write pointer and read pointer address the storage. Each pointer is one bit wider than the slot index. A three-state occupancy machine drives the full and empty indications:

- `SQ_EMPTY`: no stores are pending.
- `SQ_PARTIAL`: some stores are pending but free slots remain.
- `SQ_FULL`: every slot holds a pending store.

The machine has these transitions:

- EMPTY→PARTIAL on an accepted push.
- PARTIAL→FULL on a push without a grant when one slot is left.
- PARTIAL→EMPTY on a grant without a push when one entry is left.
- FULL→PARTIAL on a grant without a push.

In every other case the state holds. This includes a push and a grant together in FULL or PARTIAL.

Top module: `store_post_queue`

## Requirements
- R1: During reset and on the first cycle after it, `buf_empty` is 1, `mem_req` is 0 and `st_full` is 0.
- R2: A push accepted into an empty buffer appears on the memory side after one clock edge. On that cycle `mem_req` is 1, and `mem_addr` and `mem_data` equal the pushed address and data.
- R3: Entries go out on the memory port in the same order in which they were pushed.
- R4: While `mem_req` is 1 and `mem_gnt` is 0, the next cycle keeps `mem_req` at 1 with `mem_addr` and `mem_data` unchanged. The head entry leaves only on a cycle where `mem_req` and `mem_gnt` are both 1.
- R5: `st_full` is 1 exactly when DEPTH (default 8) entries are pending. A push while `st_full` is 1 and `mem_gnt` is 0 is ignored: it is never written to memory.
- R6: A push and a grant in the same cycle both take effect. At full, the pushed pair is queued behind the remaining entries and the buffer stays full.
- R7: `buf_empty` is 1 exactly when no entry is pending, and `mem_req` is then 0.
- R8: A grant while `mem_req` is 0 has no effect: the buffer stays empty, and later pushes drain with their own values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| st_push | input | 1 | Store request from the core |
| st_addr | input | AW (32) | Store address |
| st_data | input | DW (32) | Store data |
| st_full | output | 1 | Buffer full; the store must be held unless a grant frees a slot |
| mem_req | output | 1 | Write request to memory, held until granted |
| mem_addr | output | AW (32) | Address of the oldest pending store |
| mem_data | output | DW (32) | Data of the oldest pending store |
| mem_gnt | input | 1 | Memory accepts the current request this cycle |
| buf_empty | output | 1 | No posted stores remain |

## Verification
Every output is due exactly one rising edge after the push or grant that changes it; nothing combinational runs from inputs to outputs. The bench applies each cycle's push and grant just after a falling edge and updates its own queue model with the same values. At the next falling edge it compares all outputs against that model, one full edge after the stimulus. Directed sequences (reset, fill to full, ignored push at full, push with grant at full, grant on an empty buffer, long grant holdoff) precede thousands of seeded random cycles at several grant rates.

// File: rtl/spb_pkg.sv
package spb_pkg;

    typedef enum logic [1:0] {
        SQ_EMPTY   = 2'd0,
        SQ_PARTIAL = 2'd1,
        SQ_FULL    = 2'd2
    } sq_state_e;

endpackage

// File: rtl/spb_ptr.sv
// Wrapping queue pointer with one extra lap bit above the slot index.
module spb_ptr #(
    parameter int PW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          adv,
    output logic [PW-1:0] ptr
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (adv) begin
            ptr <= ptr + PW'(1);
        end
    end

endmodule

// File: rtl/spb_ram.sv
// Small distributed storage: one synchronous write, one asynchronous read.
module spb_ram #(
    parameter int DEPTH = 8,
    parameter int W     = 64,
    parameter int IW    = 3
) (
    input  logic          clk,
    input  logic          we,
    input  logic [IW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [IW-1:0] raddr,
    output logic [W-1:0]  rdata
);

    logic [W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            cells[waddr] <= wdata;
        end
    end

    assign rdata = cells[raddr];

endmodule

// File: rtl/spb_ctrl.sv
// Occupancy state machine: accept/drain decisions and full/empty flags.
module spb_ctrl
    import spb_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int PW    = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_req,
    input  logic          gnt,
    input  logic [PW-1:0] wr_ptr,
    input  logic [PW-1:0] rd_ptr,
    output logic          push_ok,
    output logic          pop,
    output logic          full,
    output logic          empty
);

    localparam logic [PW-1:0] LAST_FREE = PW'(DEPTH - 1);
    localparam logic [PW-1:0] ONE_LEFT  = PW'(1);

    sq_state_e    state_q;
    sq_state_e    state_d;
    logic [PW-1:0] occ;

    assign occ = wr_ptr - rd_ptr;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SQ_EMPTY;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SQ_EMPTY: begin
                if (push_ok) begin
                    state_d = SQ_PARTIAL;
                end
            end
            SQ_PARTIAL: begin
                if (push_ok && !pop && occ == LAST_FREE) begin
                    state_d = SQ_FULL;
                end else if (pop && !push_ok && occ == ONE_LEFT) begin
                    state_d = SQ_EMPTY;
                end
            end
            SQ_FULL: begin
                if (pop && !push_ok) begin
                    state_d = SQ_PARTIAL;
                end
            end
            default: state_d = SQ_EMPTY;
        endcase
    end

    // Outputs
    always_comb begin
        empty   = 1'b0;
        full    = 1'b0;
        pop     = 1'b0;
        push_ok = 1'b0;
        unique case (state_q)
            SQ_EMPTY: begin
                empty   = 1'b1;
                push_ok = push_req;
            end
            SQ_PARTIAL: begin
                pop     = gnt;
                push_ok = push_req;
            end
            SQ_FULL: begin
                full    = 1'b1;
                pop     = gnt;
                push_ok = push_req && gnt;
            end
            default: begin
                empty = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/store_post_queue.sv
// Posted store buffer: stores retire at once and drain in order to memory.
// DEPTH must be a power of two, at least 2.
module store_post_queue #(
    parameter int AW    = 32,
    parameter int DW    = 32,
    parameter int DEPTH = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          st_push,
    input  logic [AW-1:0] st_addr,
    input  logic [DW-1:0] st_data,
    output logic          st_full,
    output logic          mem_req,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_data,
    input  logic          mem_gnt,
    output logic          buf_empty
);

    localparam int IW = $clog2(DEPTH);
    localparam int PW = IW + 1;
    localparam int EW = AW + DW;

    logic          push_ok;
    logic          pop;
    logic          full;
    logic          empty;
    logic [PW-1:0] wr_ptr;
    logic [PW-1:0] rd_ptr;
    logic [EW-1:0] head;

    spb_ptr #(.PW(PW)) u_wptr (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (push_ok),
        .ptr   (wr_ptr)
    );

    spb_ptr #(.PW(PW)) u_rptr (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (pop),
        .ptr   (rd_ptr)
    );

    spb_ram #(.DEPTH(DEPTH), .W(EW), .IW(IW)) u_ram (
        .clk   (clk),
        .we    (push_ok),
        .waddr (wr_ptr[IW-1:0]),
        .wdata ({st_addr, st_data}),
        .raddr (rd_ptr[IW-1:0]),
        .rdata (head)
    );

    spb_ctrl #(.DEPTH(DEPTH), .PW(PW)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .push_req (st_push),
        .gnt      (mem_gnt),
        .wr_ptr   (wr_ptr),
        .rd_ptr   (rd_ptr),
        .push_ok  (push_ok),
        .pop      (pop),
        .full     (full),
        .empty    (empty)
    );

    assign st_full   = full;
    assign buf_empty = empty;
    assign mem_req   = !empty;
    assign mem_addr  = head[EW-1:DW];
    assign mem_data  = head[DW-1:0];

endmodule

// File: rtl/spb_checker.sv
module spb_checker #(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          st_push,
    input logic          st_full,
    input logic          mem_req,
    input logic [AW-1:0] mem_addr,
    input logic [DW-1:0] mem_data,
    input logic          mem_gnt,
    input logic          buf_empty
);

    // R1
    a_r1_reset_idle: assert property (@(posedge clk)
        !rst_n |=> buf_empty && !mem_req && !st_full);

    // R4
    a_r4_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_gnt |=> mem_req && $stable(mem_addr) && $stable(mem_data));

    // R5
    a_r5_full_ignores_push: assert property (@(posedge clk) disable iff (!rst_n)
        st_full && !mem_gnt |=> st_full);

    // R6
    a_r6_full_push_and_drain: assert property (@(posedge clk) disable iff (!rst_n)
        st_full && st_push && mem_gnt |=> st_full);

    // R7
    a_r7_empty_no_request: assert property (@(posedge clk) disable iff (!rst_n)
        buf_empty |-> !mem_req && !st_full);

    // R8
    a_r8_idle_grant_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        buf_empty && mem_gnt && !st_push |=> buf_empty);

endmodule

bind store_post_queue spb_checker #(.AW(AW), .DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .st_push   (st_push),
    .st_full   (st_full),
    .mem_req   (mem_req),
    .mem_addr  (mem_addr),
    .mem_data  (mem_data),
    .mem_gnt   (mem_gnt),
    .buf_empty (buf_empty)
);

// File: tb/sim_store_post_queue.sv
module sim_store_post_queue;

    localparam int CLK_PERIOD = 10;
    localparam int D          = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        st_push = 1'b0;
    logic [31:0] st_addr = '0;
    logic [31:0] st_data = '0;
    logic        mem_gnt = 1'b0;
    logic        st_full;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic [31:0] mem_data;
    logic        buf_empty;

    int nchk = 0;
    int nfail = 0;

    logic [31:0] qa [D];
    logic [31:0] qd [D];
    int head = 0;
    int cnt = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    store_post_queue #(.AW(32), .DW(32), .DEPTH(D)) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .st_push   (st_push),
        .st_addr   (st_addr),
        .st_data   (st_data),
        .st_full   (st_full),
        .mem_req   (mem_req),
        .mem_addr  (mem_addr),
        .mem_data  (mem_data),
        .mem_gnt   (mem_gnt),
        .buf_empty (buf_empty)
    );

    function automatic logic [31:0] mk_addr(int i);
        return 32'h4000_0000 + 32'(i) * 32'd4;
    endfunction

    function automatic logic [31:0] mk_data(int i);
        return (32'(i) * 32'h9E37_79B9) ^ 32'h5A5A_0F0F;
    endfunction

    task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic check_outputs();
        chk(buf_empty == (cnt == 0), "R7 buf_empty", 32'(buf_empty), 32'(cnt == 0));
        chk(st_full == (cnt == D), "R5 st_full", 32'(st_full), 32'(cnt == D));
        chk(mem_req == (cnt > 0), "R4 mem_req", 32'(mem_req), 32'(cnt > 0));
        if (cnt > 0) begin
            chk(mem_addr == qa[head], "R3 mem_addr order", mem_addr, qa[head]);
            chk(mem_data == qd[head], "R2 mem_data", mem_data, qd[head]);
        end
    endtask

    // Called just after a falling edge: check, drive, update model, wait.
    task automatic step(bit push, logic [31:0] a, logic [31:0] d, bit gnt);
        bit pop;
        bit acc;
        int tail;
        check_outputs();
        st_push = push;
        st_addr = a;
        st_data = d;
        mem_gnt = gnt;
        pop  = gnt && (cnt > 0);
        acc  = push && ((cnt < D) || pop);
        tail = (head + cnt) % D;
        if (acc) begin
            qa[tail] = a;
            qd[tail] = d;
        end
        if (pop) head = (head + 1) % D;
        cnt = cnt - int'(pop) + int'(acc);
        @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        nfail++;
        nchk++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin : main
        int idx;
        logic [31:0] held_a;
        void'($urandom(32'd20240607));
        idx = 0;

        // R1: reset state
        repeat (3) @(negedge clk);
        chk(buf_empty == 1'b1, "R1 empty in reset", 32'(buf_empty), 32'd1);
        chk(mem_req == 1'b0, "R1 req in reset", 32'(mem_req), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(st_full == 1'b0, "R1 full after reset", 32'(st_full), 32'd0);
        chk(mem_req == 1'b0 && buf_empty, "R1 idle after reset", 32'(mem_req), 32'd0);

        // R8: grant on empty buffer
        step(1'b0, '0, '0, 1'b1);
        step(1'b0, '0, '0, 1'b1);
        chk(buf_empty == 1'b1, "R8 grant while idle", 32'(buf_empty), 32'd1);

        // R2: single push reaches memory side after one edge
        step(1'b1, mk_addr(idx), mk_data(idx), 1'b0); idx++;
        chk(mem_req && mem_addr == mk_addr(0), "R2 first store visible", mem_addr, mk_addr(0));

        // R4: hold without grant, address stays
        held_a = mem_addr;
        for (int k = 0; k < 5; k++) step(1'b0, '0, '0, 1'b0);
        chk(mem_addr == held_a && mem_req, "R4 held request", mem_addr, held_a);

        // R5: fill to full with no grant, then pushes ignored
        while (cnt < D) begin
            step(1'b1, mk_addr(idx), mk_data(idx), 1'b0); idx++;
        end
        chk(st_full == 1'b1, "R5 full after fill", 32'(st_full), 32'd1);
        for (int k = 0; k < 3; k++) step(1'b1, 32'hDEAD_0000 + 32'(k), 32'hBAD0_0000, 1'b0);
        chk(st_full == 1'b1 && mem_addr == qa[head], "R5 ignored push", mem_addr, qa[head]);

        // R6: push and grant together at full
        for (int k = 0; k < 4; k++) begin
            step(1'b1, mk_addr(idx), mk_data(idx), 1'b1); idx++;
        end
        chk(st_full == 1'b1, "R6 stays full", 32'(st_full), 32'd1);

        // R3: drain in order
        while (cnt > 0) step(1'b0, '0, '0, 1'b1);
        chk(buf_empty == 1'b1, "R7 drained", 32'(buf_empty), 32'd1);

        // Random phases at different grant rates
        for (int ph = 0; ph < 4; ph++) begin
            int gp;
            int pp;
            gp = (ph == 0) ? 20 : (ph == 1) ? 50 : (ph == 2) ? 90 : 35;
            pp = (ph == 2) ? 40 : 70;
            for (int c = 0; c < 1500; c++) begin
                bit p;
                bit g;
                p = ($urandom_range(99) < pp);
                g = ($urandom_range(99) < gp);
                step(p, $urandom, $urandom, g);
            end
        end
        while (cnt > 0) step(1'b0, '0, '0, 1'b1);
        step(1'b0, '0, '0, 1'b0);
        chk(buf_empty == 1'b1 && !mem_req, "R7 final empty", 32'(buf_empty), 32'd1);

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

endmodule